// File: doc/BRIEF.md
# Processor Status Register with Protected Flags

This block holds the 8-bit status word of a small accumulator-style processor core. The word carries the three arithmetic flags (zero, digit carry, carry), one bank-select bit that picks the upper or lower half of data memory, two reserved bits, and two reset-cause bits that report whether the last wake-up came from a watchdog time-out or from a low-power sleep.

Software can write the register like any other file register. Two rules make it differ from plain storage. When the same instruction also drives the arithmetic flags, the flag result from the ALU wins over the written value for each flag that is being updated. The two reset-cause bits ignore register writes and move only on system events: power-on, watchdog clear, sleep entry and watchdog time-out. Every change takes effect on the clock edge that completes the instruction, so a read in that cycle still returns the old value.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge the register resets to reserved bits 0, bank-select 0, time-out 1 and power-down 1. The three flags also reset to 0 but are not defined to software.
- R2: The bit positions of `rd_data`, from bit 7 down to bit 0, are reserved, reserved, bank-select, time-out, power-down, Z, DC, C. `bank_sel` always equals bit 5 (1 selects addresses 80h–FFh, 0 selects 00h–7Fh).
- R3: A write (`wr_en` high, `clr_en` low) loads bits 7:5 and every flag whose update enable is low from `wr_data` on the next rising edge. In the cycle of the write `rd_data` still shows the old value.
- R4: Bits 4:3 (time-out, power-down) never change because of a write or a clear.
- R5: `flag_upd` and `flag_val` use the order {Z, DC, C} (index 2 is Z, index 0 is C). A flag whose update enable is high takes its `flag_val` bit, whatever `wr_en` or `clr_en` request for that flag in the same cycle.
- R6: A clear (`clr_en` high) sets bits 7:5 to 0 and Z to 1 and leaves DC, C, time-out and power-down unchanged, giving 000u u1uu. It takes precedence over `wr_en`.
- R7: A power-on strobe sets time-out and power-down to 1.
- R8: A watchdog time-out strobe clears time-out and leaves power-down unchanged.
- R9: A sleep strobe sets time-out to 1 and clears power-down.
- R10: A watchdog-clear strobe sets time-out and power-down to 1.
- R11: When several strobes arrive in the same cycle, only the highest one acts. The order is power-on, then watchdog time-out, then sleep, then watchdog clear.
- R12: With `wr_en` and `clr_en` low, the flags with their update enable high change and every other bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register-file write aimed at the status register |
| clr_en | input | 1 | Clear-register operation aimed at the status register |
| wr_data | input | 8 | Write data |
| flag_upd | input | 3 | Per-flag update enables {Z, DC, C} |
| flag_val | input | 3 | ALU flag results {Z, DC, C} |
| por_evt | input | 1 | Power-on strobe |
| wdt_clr_evt | input | 1 | Watchdog-clear strobe |
| sleep_evt | input | 1 | Sleep-entry strobe |
| wdt_to_evt | input | 1 | Watchdog time-out strobe |
| rd_data | output | 8 | Current status word |
| bank_sel | output | 1 | Data-memory bank select |

## Verification
Two functions can meet in one cycle: a software write or clear and an ALU flag update that both target the same flags. The bench drives both in a single cycle with differing values, and checks that each updated flag shows the ALU value while the rest follow the write or the clear. A write to the cause bits is also issued in the same cycle as a sleep or time-out strobe, and the bench checks that the cause bits follow the event and ignore the written data. Stacked strobes are applied together to confirm that only the highest one acts.

// File: rtl/stat_pkg.sv
// Package: shared bit positions and event encoding for the status register.
// Assumes an 8-bit word; the bit order is fixed because the address
// decoder and the ALU read fixed positions.
package stat_pkg;
    localparam int STAT_W   = 8;
    localparam int NFLAG    = 3;
    localparam int NCTRL    = 3;
    localparam int BIT_C    = 0;
    localparam int BIT_DC   = 1;
    localparam int BIT_Z    = 2;
    localparam int BIT_PD   = 3;
    localparam int BIT_TO   = 4;
    localparam int BIT_BANK = 5;
    localparam int CTRL_LO  = BIT_BANK;
    localparam int CTRL_HI  = STAT_W - 1;

    // Highest-priority system event seen in one cycle.
    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_POR     = 3'd1,
        EV_WDT_TO  = 3'd2,
        EV_SLEEP   = 3'd3,
        EV_WDT_CLR = 3'd4
    } sys_event_e;

    typedef struct packed {
        logic tmo;
        logic pwd;
    } cause_t;
endpackage

// File: rtl/status_event_arb.sv
// status_event_arb: reduces the four system strobes to one event code.
// Assumes strobes are single-cycle pulses, synchronous to clk.
// Priority: power-on, watchdog time-out, sleep, watchdog clear.
module status_event_arb
    import stat_pkg::*;
(
    input  logic       por_evt,
    input  logic       wdt_to_evt,
    input  logic       sleep_evt,
    input  logic       wdt_clr_evt,
    output sys_event_e ev
);
    // Fixed-priority pick of the winning strobe.
    always_comb begin
        if (por_evt)          ev = EV_POR;
        else if (wdt_to_evt)  ev = EV_WDT_TO;
        else if (sleep_evt)   ev = EV_SLEEP;
        else if (wdt_clr_evt) ev = EV_WDT_CLR;
        else                  ev = EV_NONE;
    end
endmodule

// File: rtl/status_cause_bits.sv
// status_cause_bits: time-out and power-down reset-cause bits.
// Assumes the event code is already arbitrated. There is no write path,
// so software cannot touch these bits. Reset value is 1 for both.
module status_cause_bits
    import stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sys_event_e ev,
    output cause_t     cause
);
    cause_t cause_q;
    cause_t cause_d;

    // Next-state rule for each event kind.
    always_comb begin
        cause_d = cause_q;
        unique case (ev)
            EV_POR:     begin cause_d.tmo = 1'b1; cause_d.pwd = 1'b1; end
            EV_WDT_TO:  begin cause_d.tmo = 1'b0; end
            EV_SLEEP:   begin cause_d.tmo = 1'b1; cause_d.pwd = 1'b0; end
            EV_WDT_CLR: begin cause_d.tmo = 1'b1; cause_d.pwd = 1'b1; end
            default:    cause_d = cause_q;
        endcase
    end

    // Cause register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '{tmo: 1'b1, pwd: 1'b1};
        else        cause_q <= cause_d;
    end

    assign cause = cause_q;

    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_NONE) |=> $stable(cause_q)); // R4
    AST_POR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_POR) |=> (cause_q.tmo && cause_q.pwd)); // R7
    AST_WDT_TO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_WDT_TO) |=> (!cause_q.tmo && cause_q.pwd == $past(cause_q.pwd))); // R8
    AST_SLEEP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SLEEP) |=> (cause_q.tmo && !cause_q.pwd)); // R9
    AST_WDT_CLR_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_WDT_CLR) |=> (cause_q.tmo && cause_q.pwd)); // R10
endmodule

// File: rtl/status_alu_flags.sv
// status_alu_flags: the arithmetic flags with per-flag ALU override.
// Assumes the ALU update enables and values are valid in the cycle
// that completes the instruction. Per flag, the ALU update wins over
// a clear, and a clear wins over a write. CLR_SET selects the flags
// that a clear sets to 1 (Z only); the others hold on a clear.
module status_alu_flags #(
    parameter int                 N       = 3,
    parameter logic [N-1:0]       CLR_SET = 3'b100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         clr_en,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] upd,
    input  logic [N-1:0] val,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic nxt;

        // Per-flag source select: ALU, then clear, then write, then hold.
        always_comb begin
            if (upd[i])                     nxt = val[i];
            else if (clr_en && CLR_SET[i])  nxt = 1'b1;
            else if (clr_en)                nxt = flags_q[i];
            else if (wr_en)                 nxt = wr_bits[i];
            else                            nxt = flags_q[i];
        end

        // Flag storage; reset value is for simulation only.
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= nxt;
        end

        AST_ALU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            upd[i] |=> (flags_q[i] == $past(val[i]))); // R5
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!upd[i] && !wr_en && !clr_en) |=> $stable(flags_q[i])); // R12
    end

    assign flags = flags_q;
endmodule

// File: rtl/status_ctrl_bits.sv
// status_ctrl_bits: bank-select and the two reserved bits.
// Assumes bit 0 of this slice is the bank select. Plain read/write
// storage; a clear forces all of them to 0 and wins over a write.
module status_ctrl_bits #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         clr_en,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] bits
);
    logic [N-1:0] bits_q;

    // Control storage: clear, then write, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      bits_q <= '0;
        else if (clr_en) bits_q <= '0;
        else if (wr_en)  bits_q <= wr_bits;
    end

    assign bits = bits_q;

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (bits_q == '0)); // R6
    AST_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_en) |=> (bits_q == $past(wr_bits))); // R3
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_en) |=> $stable(bits_q)); // R3
endmodule

// File: rtl/cpu_status_reg.sv
// cpu_status_reg: 8-bit processor status register.
// Assumes one instruction completes per enabled clock edge and that
// the decoder raises wr_en or clr_en only when this register is the
// destination. Reads are registered values: a change made by an
// instruction is visible from the cycle after it completes.
module cpu_status_reg
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [NFLAG-1:0]  flag_upd,
    input  logic [NFLAG-1:0]  flag_val,
    input  logic              por_evt,
    input  logic              wdt_clr_evt,
    input  logic              sleep_evt,
    input  logic              wdt_to_evt,
    output logic [STAT_W-1:0] rd_data,
    output logic              bank_sel
);
    sys_event_e        ev;
    cause_t            cause;
    logic [NFLAG-1:0]  flags;
    logic [NCTRL-1:0]  ctrl;

    status_event_arb u_arb (
        .por_evt     (por_evt),
        .wdt_to_evt  (wdt_to_evt),
        .sleep_evt   (sleep_evt),
        .wdt_clr_evt (wdt_clr_evt),
        .ev          (ev)
    );

    status_cause_bits u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .cause (cause)
    );

    status_alu_flags #(
        .N       (NFLAG),
        .CLR_SET (NFLAG'(1) << (BIT_Z - BIT_C))
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .clr_en  (clr_en),
        .wr_bits (wr_data[BIT_Z:BIT_C]),
        .upd     (flag_upd),
        .val     (flag_val),
        .flags   (flags)
    );

    status_ctrl_bits #(
        .N (NCTRL)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .clr_en  (clr_en),
        .wr_bits (wr_data[CTRL_HI:CTRL_LO]),
        .bits    (ctrl)
    );

    // Assemble the read word in its fixed bit order.
    always_comb begin
        rd_data                  = '0;
        rd_data[CTRL_HI:CTRL_LO] = ctrl;
        rd_data[BIT_TO]          = cause.tmo;
        rd_data[BIT_PD]          = cause.pwd;
        rd_data[BIT_Z:BIT_C]     = flags;
    end

    assign bank_sel = ctrl[0];

    AST_WRITE_CAUSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || clr_en) && !por_evt && !wdt_to_evt && !sleep_evt && !wdt_clr_evt
         && (wr_data[BIT_TO:BIT_PD] != rd_data[BIT_TO:BIT_PD]))
        |=> $stable(rd_data[BIT_TO:BIT_PD])); // R4
    AST_POR_OVER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (por_evt && (wdt_to_evt || sleep_evt)) |=> (rd_data[BIT_TO] && rd_data[BIT_PD])); // R11
    AST_TO_OVER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_evt && wdt_to_evt && sleep_evt) |=> !rd_data[BIT_TO]); // R11
    AST_BANK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel == rd_data[BIT_BANK]); // R2
endmodule

// File: tb/cpu_status_reg_test.sv
// Scoreboard bench: the driver applies one instruction per cycle and
// pushes the expected word; the monitor pops and compares it.
module cpu_status_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, clr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] flag_upd = '0, flag_val = '0;
    logic       por_evt = 1'b0, wdt_clr_evt = 1'b0, sleep_evt = 1'b0, wdt_to_evt = 1'b0;
    logic [7:0] rd_data;
    logic       bank_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_word;
    bit         m_flags_known = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] mask_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    cpu_status_reg uut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .clr_en (clr_en),
        .wr_data (wr_data), .flag_upd (flag_upd), .flag_val (flag_val),
        .por_evt (por_evt), .wdt_clr_evt (wdt_clr_evt), .sleep_evt (sleep_evt),
        .wdt_to_evt (wdt_to_evt), .rd_data (rd_data), .bank_sel (bank_sel)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp,
                         input logic [7:0] mask, input string tag);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            errors++;
            $display("FAIL %s actual %h expected %h (mask %h)", tag, act, exp, mask);
        end
    endtask

    function automatic logic [7:0] cur_mask();
        return m_flags_known ? 8'hFF : 8'hF8;
    endfunction

    // Monitor: compare each result one half-cycle after its edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e, m;
            string t;
            e = exp_q.pop_front();
            m = mask_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data, e, m, t);
            check({7'b0, bank_sel}, {7'b0, rd_data[5]}, 8'h01, {t, " R2 bank pin"});
        end
    end

    // Driver: apply one instruction, check the old value, push the new one.
    task automatic step(input logic w, input logic c, input logic [7:0] d,
                        input logic [2:0] u, input logic [2:0] v,
                        input logic por, input logic wto, input logic slp,
                        input logic wcl, input string tag);
        logic [7:0] nx;
        @(negedge clk);
        wr_en = w; clr_en = c; wr_data = d; flag_upd = u; flag_val = v;
        por_evt = por; wdt_to_evt = wto; sleep_evt = slp; wdt_clr_evt = wcl;
        #1;
        check(rd_data, m_word, cur_mask(), {tag, " R3 old value before edge"});
        nx = m_word;
        if (c) begin nx[7:5] = 3'b000; nx[2] = 1'b1; end
        else if (w) begin nx[7:5] = d[7:5]; nx[2:0] = d[2:0]; end
        for (int i = 0; i < 3; i++) if (u[i]) nx[i] = v[i];
        if (por)      nx[4:3] = 2'b11;
        else if (wto) nx[4]   = 1'b0;
        else if (slp) nx[4:3] = 2'b10;
        else if (wcl) nx[4:3] = 2'b11;
        if (w && !c) m_flags_known = 1'b1;
        m_word = nx;
        @(posedge clk);
        exp_q.push_back(nx);
        mask_q.push_back(cur_mask());
        tag_q.push_back(tag);
        #1;
        wr_en = 1'b0; clr_en = 1'b0; flag_upd = '0; flag_val = '0;
        por_evt = 1'b0; wdt_to_evt = 1'b0; sleep_evt = 1'b0; wdt_clr_evt = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_word = 8'b0001_1000;
        check(rd_data, m_word, 8'hF8, "R1 reset state");
        check({7'b0, bank_sel}, 8'h00, 8'h01, "R1 bank after reset");
        rst_n = 1'b1;

        step(1, 0, 8'hFF, 3'b000, 3'b000, 0, 0, 0, 0, "R3 R4 write all ones");
        step(1, 0, 8'h07, 3'b100, 3'b000, 0, 0, 0, 0, "R5 Z override on write");
        step(0, 0, 8'h00, 3'b011, 3'b010, 0, 0, 0, 0, "R12 flag update only");
        step(0, 0, 8'hFF, 3'b000, 3'b000, 0, 0, 0, 0, "R12 idle hold");
        step(1, 1, 8'hFF, 3'b000, 3'b000, 0, 0, 0, 0, "R6 clear beats write");
        step(1, 0, 8'hA5, 3'b000, 3'b000, 0, 0, 0, 0, "R3 write pattern A5");
        step(0, 1, 8'h00, 3'b101, 3'b001, 0, 0, 0, 0, "R6 R5 clear with ALU flags");
        step(0, 0, 8'h00, 3'b000, 3'b000, 0, 0, 1, 0, "R9 sleep");
        step(0, 0, 8'h00, 3'b000, 3'b000, 0, 1, 0, 0, "R8 wdt time-out");
        step(1, 0, 8'h18, 3'b000, 3'b000, 0, 0, 0, 0, "R4 write to cause bits ignored");
        step(0, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0, 1, "R10 wdt clear");
        step(1, 0, 8'h00, 3'b000, 3'b000, 0, 1, 0, 0, "R8 R4 time-out with write");
        step(0, 1, 8'h00, 3'b000, 3'b000, 0, 0, 0, 0, "R6 R4 clear leaves causes");
        step(0, 0, 8'h00, 3'b000, 3'b000, 1, 0, 0, 0, "R7 power-on");
        step(1, 0, 8'h47, 3'b010, 3'b000, 0, 0, 1, 1, "R11 sleep over wdt clear");
        step(0, 0, 8'h00, 3'b000, 3'b000, 0, 1, 1, 1, "R11 time-out over sleep");
        step(0, 0, 8'h00, 3'b000, 3'b000, 1, 1, 1, 1, "R11 power-on over all");
        step(1, 0, 8'h20, 3'b000, 3'b000, 0, 0, 0, 0, "R2 bank select high");
        step(1, 0, 8'hC0, 3'b111, 3'b111, 0, 0, 0, 0, "R2 R5 reserved bits, all ALU");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule